// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire System Bus

This block is a target on an SMBus-style two-wire bus. It holds a small bank of 8-bit configuration registers that downstream logic reads in parallel at all times. After reset every register holds its default value, so a system can run without ever touching the bus. A host can change or inspect the registers one at a time, or move a run of them in a single block transfer.

The block samples both bus lines with the system clock through two-flop synchronisers. It finds start and stop conditions from data-line edges while the clock line is high. It drives the data line only by pulling it low, through an output-enable, and changes that enable only while the clock line is low. The first data byte after the address is a command. When its top bit is set, the other seven bits select one register. When its top bit is clear, it opens a block transfer that starts at register 0. In a block write the host sends a byte count before the data. In a block read the target first returns a count equal to the number of registers, then the registers in ascending order.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, register i holds its default value, 8'hA0 + i with the default parameters, and `reg_bus[8*i +: 8]` presents it. The data line is released.
- R2: The target acknowledges only address byte 8'hD2 (write) or 8'hD3 (read). Any other address gets no acknowledge, and the rest of that transaction has no effect on the registers.
- R3: A byte write is address D2, a command with bit 7 set and the offset in bits 6:0, then one data byte. It stores the data in that register and every byte is acknowledged.
- R4: A byte read is address D2, a command with bit 7 set, a repeated start, then address D3. The target returns the addressed register, most significant bit first.
- R5: A command with bit 7 set and an offset at or above the register count (8) is not acknowledged. The data that follows changes nothing.
- R6: Registers 0 and 7 are read-only. Writes to them are acknowledged and leave their contents unchanged.
- R7: A block write is command 8'h00, a byte count, then data bytes. The data goes to registers 0, 1, 2, ... in order. A stop after any complete byte leaves the later registers unchanged.
- R8: In a block write, a data byte beyond the byte count, or beyond the last register, is not acknowledged and not stored.
- R9: A block read is command 8'h00, a repeated start, then address D3. The target returns the count 8 and then registers 0 to 7 in ascending order. A master NACK ends the transfer.
- R10: A command with bit 7 clear and any of bits 6:0 set is not acknowledged.
- R11: The target changes its data-line enable only while the clock line is low.
- R12: A stop in the middle of a transaction returns the target to idle without a write, and the next start is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | When high, the data line is pulled low |
| reg_bus | output | NUM_REGS*8 | All registers side by side, register i in bits 8*i+7:8*i |

## Verification
The sharpest collision is in a block write of count 8 followed by a ninth byte. On the eighth byte, the register store, the count running out and the pointer reaching the end of the bank all happen at the same byte boundary. That last byte must still be stored and acknowledged. Only the ninth must be refused, and register 7 must keep its default because it is read-only. The bench judges this from the acknowledge bits it samples and from the parallel register bus. It then confirms every register with a block read.

// File: rtl/smb_cfg_pkg.sv
// Shared types for the two-wire configuration slave.
// Assumes: nothing beyond standard SystemVerilog packages.
package smb_cfg_pkg;

    // Protocol phases of the slave; the receive phases share one byte engine.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_CNT,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } smb_state_e;

endpackage

// File: rtl/smb_line_sync.sv
// Synchronises the bus clock and data lines into the system clock domain
// and flags clock edges plus start and stop conditions.
// Assumes: the system clock runs several times faster than the bus clock,
// and the lines idle high.
module smb_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [1:0] scl_ff;
    logic [1:0] sda_ff;
    logic       scl_d;
    logic       sda_d;
    logic       scl_s;

    // Two-flop synchronisers plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_d  <= scl_ff[1];
            sda_d  <= sda_ff[1];
        end
    end

    assign scl_s = scl_ff[1];
    assign sda_s = sda_ff[1];

    // Edge and bus-condition decode from synchronised samples.
    always_comb begin
        scl_rise = scl_s & ~scl_d;
        scl_fall = ~scl_s & scl_d;
        start_ev = scl_s & scl_d & sda_d & ~sda_s;
        stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/smb_reg_bank.sv
// Bank of 8-bit configuration registers with per-register read-only option,
// a single write port and a pointer-indexed read port.
// Assumes: writes arrive as single-cycle strobes; a read index past the
// last register returns all ones.
module smb_reg_bank #(
    parameter int                      NUM_REGS = 8,
    parameter int                      PW       = $clog2(NUM_REGS + 1),
    parameter logic [NUM_REGS-1:0]     RO_MASK  = '0,
    parameter logic [NUM_REGS*8-1:0]   DEFAULTS = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PW-1:0]         wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [PW-1:0]         rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] reg_bus
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (RO_MASK[g]) begin : g_ro
            // Read-only register: fixed at its default value.
            assign reg_bus[g*8 +: 8] = DEFAULTS[g*8 +: 8];
        end else begin : g_rw
            logic [7:0] q;
            // Writable register: default at reset, load on a matching strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= DEFAULTS[g*8 +: 8];
                else if (wr_en && (wr_idx == PW'(g)))
                    q <= wr_data;
            end
            assign reg_bus[g*8 +: 8] = q;
        end
    end

    // Read multiplexer over the parallel bus.
    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == PW'(i))
                rd_data = reg_bus[i*8 +: 8];
        end
    end

endmodule

// File: rtl/smb_proto_fsm.sv
// Protocol engine of the slave: receives address, command, count and data
// bytes, decides acknowledges, drives read data, and steps a register pointer.
// Assumes: synchronised line events from smb_line_sync; no clock stretching.
module smb_proto_fsm
    import smb_cfg_pkg::*;
#(
    parameter int         NUM_REGS = 8,
    parameter int         PW       = $clog2(NUM_REGS + 1),
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_ev,
    input  logic          stop_ev,
    input  logic [7:0]    rd_data,
    output logic          wr_en,
    output logic [PW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic [PW-1:0] rd_idx,
    output logic          sda_oe,
    output smb_state_e    state
);

    localparam logic [PW-1:0] PTR_END = PW'(NUM_REGS);

    smb_state_e    nxt_st;
    logic [7:0]    sh;
    logic [3:0]    bcnt;
    logic          ack_drv;
    logic          blk;
    logic [PW-1:0] ptr;
    logic [7:0]    wcnt;
    logic [7:0]    txb;
    logic          mack;
    logic          byte_done;
    logic          ptr_ok;
    logic          wr_ok;
    logic [PW-1:0] ptr_inc;

    // Byte completion, write permission and saturating pointer step.
    always_comb begin
        byte_done = scl_fall && (bcnt == 4'd8);
        ptr_ok    = ptr < PTR_END;
        wr_ok     = ptr_ok && (wcnt != 8'd0);
        ptr_inc   = ptr_ok ? ptr + PW'(1) : ptr;
        wr_en     = (state == ST_WDATA) && byte_done && wr_ok;
        wr_idx    = ptr;
        wr_data   = sh;
        rd_idx    = ptr;
    end

    // Data-line pull-down: acknowledge slot or a zero bit being sent.
    assign sda_oe = ((state == ST_ACK) && ack_drv) || ((state == ST_TX) && !txb[7]);

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            nxt_st  <= ST_IDLE;
            sh      <= '0;
            bcnt    <= '0;
            ack_drv <= 1'b0;
            blk     <= 1'b0;
            ptr     <= '0;
            wcnt    <= '0;
            txb     <= 8'hFF;
            mack    <= 1'b0;
        end else if (start_ev) begin
            state   <= ST_ADDR;
            bcnt    <= '0;
            ack_drv <= 1'b0;
            txb     <= 8'hFF;
        end else if (stop_ev) begin
            state   <= ST_IDLE;
            ack_drv <= 1'b0;
            txb     <= 8'hFF;
        end else begin
            case (state)
                ST_ADDR, ST_CMD, ST_CNT, ST_WDATA: begin
                    if (scl_rise && (bcnt < 4'd8)) begin
                        sh   <= {sh[6:0], sda_s};
                        bcnt <= bcnt + 4'd1;
                    end
                    if (byte_done) begin
                        bcnt  <= '0;
                        state <= ST_ACK;
                        case (state)
                            ST_ADDR: begin
                                if (sh[7:1] == DEV_ADDR) begin
                                    ack_drv <= 1'b1;
                                    if (!sh[0]) begin
                                        nxt_st <= ST_CMD;
                                    end else begin
                                        nxt_st <= ST_TX;
                                        if (blk) begin
                                            txb <= 8'(NUM_REGS);
                                        end else begin
                                            txb <= rd_data;
                                            ptr <= ptr_inc;
                                        end
                                    end
                                end else begin
                                    ack_drv <= 1'b0;
                                    nxt_st  <= ST_SKIP;
                                end
                            end
                            ST_CMD: begin
                                if (sh[7] && (int'(sh[6:0]) < NUM_REGS)) begin
                                    ack_drv <= 1'b1;
                                    blk     <= 1'b0;
                                    ptr     <= PW'(sh[6:0]);
                                    wcnt    <= 8'd1;
                                    nxt_st  <= ST_WDATA;
                                end else if (!sh[7] && (sh[6:0] == 7'd0)) begin
                                    ack_drv <= 1'b1;
                                    blk     <= 1'b1;
                                    ptr     <= '0;
                                    nxt_st  <= ST_CNT;
                                end else begin
                                    ack_drv <= 1'b0;
                                    nxt_st  <= ST_SKIP;
                                end
                            end
                            ST_CNT: begin
                                ack_drv <= 1'b1;
                                wcnt    <= sh;
                                nxt_st  <= ST_WDATA;
                            end
                            default: begin
                                if (wr_ok) begin
                                    ack_drv <= 1'b1;
                                    ptr     <= ptr_inc;
                                    wcnt    <= wcnt - 8'd1;
                                    nxt_st  <= ST_WDATA;
                                end else begin
                                    ack_drv <= 1'b0;
                                    nxt_st  <= ST_SKIP;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        ack_drv <= 1'b0;
                        state   <= nxt_st;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bcnt == 4'd7) begin
                            bcnt  <= '0;
                            txb   <= 8'hFF;
                            state <= ST_MACK;
                        end else begin
                            txb  <= {txb[6:0], 1'b1};
                            bcnt <= bcnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise)
                        mack <= ~sda_s;
                    if (scl_fall) begin
                        if (mack) begin
                            txb   <= rd_data;
                            ptr   <= ptr_inc;
                            state <= ST_TX;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/smb_cfg_slave.sv
// Top of the configuration register slave: line synchroniser, protocol
// engine and register bank, with all registers exposed in parallel.
// Assumes: open-drain lines resolved outside; sda_oe high pulls data low.
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int                    NUM_REGS = 8,
    parameter logic [6:0]            DEV_ADDR = 7'h69,
    parameter logic [NUM_REGS-1:0]   RO_MASK  = 8'h81,
    parameter logic [NUM_REGS*8-1:0] DEFAULTS = 64'hA7A6_A5A4_A3A2_A1A0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] reg_bus
);

    localparam int PW = $clog2(NUM_REGS + 1);

    logic          sda_s;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_ev;
    logic          stop_ev;
    logic          wr_en;
    logic [PW-1:0] wr_idx;
    logic [7:0]    wr_data;
    logic [PW-1:0] rd_idx;
    logic [7:0]    rd_data;
    smb_state_e    fsm_state;

    smb_line_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    smb_proto_fsm #(
        .NUM_REGS (NUM_REGS),
        .PW       (PW),
        .DEV_ADDR (DEV_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .sda_oe   (sda_oe),
        .state    (fsm_state)
    );

    smb_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .PW       (PW),
        .RO_MASK  (RO_MASK),
        .DEFAULTS (DEFAULTS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .reg_bus (reg_bus)
    );

endmodule

// File: rtl/smb_cfg_chk.sv
// Property checker for smb_cfg_slave, attached by bind.
// Assumes: connected to the top's internal event, strobe and state signals.
module smb_cfg_chk
    import smb_cfg_pkg::*;
#(
    parameter int                  NUM_REGS = 8,
    parameter int                  PW       = $clog2(NUM_REGS + 1),
    parameter logic [NUM_REGS-1:0] RO_MASK  = '0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_oe,
    input smb_state_e            state,
    input logic                  start_ev,
    input logic                  wr_en,
    input logic [PW-1:0]         wr_idx,
    input logic [NUM_REGS*8-1:0] reg_bus
);

    // R11: data-line enable changes only while the raw clock line is low.
    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R12: a start condition always leads to address reception.
    p_start_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_ADDR));

    // R5: a register store never targets an index outside the bank.
    p_wr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NUM_REGS));

    // R6: a store aimed at a read-only register leaves the bus unchanged.
    p_ro_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) < NUM_REGS) && RO_MASK[wr_idx]) |=> $stable(reg_bus));

    // R2: while idle or ignoring a transaction the slave never pulls data low.
    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) || (state == ST_SKIP)) |-> !sda_oe);

endmodule

bind smb_cfg_slave smb_cfg_chk #(
    .NUM_REGS (NUM_REGS),
    .RO_MASK  (RO_MASK)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .state    (fsm_state),
    .start_ev (start_ev),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .reg_bus  (reg_bus)
);

// File: tb/smb_cfg_slave_tb.sv
// Self-checking bench: a bus master model drives the slave, a vector table
// covers byte access, then directed tests cover block modes and corners.
module smb_cfg_slave_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        sda_line;
    logic [63:0] reg_bus;
    int          n_chk = 0;
    int          n_err = 0;
    int          oe_viol = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    smb_cfg_slave dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .reg_bus (reg_bus)
    );

    // Counts enable changes seen while the clock line is high (R11).
    always @(sda_oe) if (rst_n && scl_m) oe_viol++;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r);
        sda_m = b; wt(5);
        scl_m = 1'b1; wt(5);
        r = sda_line; wt(5);
        scl_m = 1'b0; wt(5);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(5);
        scl_m = 1'b1; wt(5);
        sda_m = 1'b0; wt(5);
        scl_m = 1'b0; wt(5);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(5);
        scl_m = 1'b1; wt(5);
        sda_m = 1'b1; wt(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) xbit(b[i], r);
        xbit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            xbit(1'b1, r);
            b[i] = r;
        end
        xbit(~give_ack, r);
    endtask

    task automatic byte_write(input logic [7:0] off, input logic [7:0] d,
                              output logic a0, output logic a1, output logic a2);
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(8'h80 | off, a1);
        send_byte(d, a2);
        bus_stop();
    endtask

    task automatic byte_read(input logic [7:0] off, output logic [7:0] d);
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h80 | off, a);
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    function automatic int regv(input int i);
        return int'(reg_bus[i*8 +: 8]);
    endfunction

    // Vectors: {offset, written data, expected read-back}.
    localparam logic [23:0] VEC [6] = '{
        {8'h01, 8'h5A, 8'h5A},
        {8'h02, 8'hC3, 8'hC3},
        {8'h00, 8'h55, 8'hA0},
        {8'h07, 8'h11, 8'hA7},
        {8'h06, 8'hFF, 8'hFF},
        {8'h03, 8'h00, 8'h00}
    };

    logic       finished = 1'b0;

    initial begin : main
        logic       a0, a1, a2;
        logic [7:0] d;
        logic [7:0] exp_bank [8];

        wt(5);
        rst_n = 1'b1;
        wt(5);

        // R1: defaults after reset and data line released.
        for (int i = 0; i < 8; i++) chk("R1 default", regv(i), 8'hA0 + i);
        chk("R1 sda released", int'(sda_oe), 0);

        // R3 / R4 / R6: table of byte writes, each read back.
        for (int i = 0; i < 6; i++) begin
            byte_write(VEC[i][23:16], VEC[i][15:8], a0, a1, a2);
            chk("R3 byte write acks", int'({a0, a1, a2}), 7);
            byte_read(VEC[i][23:16], d);
            if (VEC[i][15:8] != VEC[i][7:0])
                chk("R6 read-only unchanged", int'(d), int'(VEC[i][7:0]));
            else
                chk("R4 byte read value", int'(d), int'(VEC[i][7:0]));
            chk("R3 parallel bus", regv(int'(VEC[i][23:16])), int'(VEC[i][7:0]));
        end

        // R2: foreign address not acknowledged and no effect.
        bus_start();
        send_byte(8'hA4, a0);
        send_byte(8'h81, a1);
        send_byte(8'h00, a2);
        bus_stop();
        chk("R2 foreign address nack", int'(a0), 0);
        chk("R2 foreign no write", regv(1), 8'h5A);

        // R5: out-of-range offset refused, following data ignored.
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(8'h88, a1);
        send_byte(8'h99, a2);
        bus_stop();
        chk("R5 offset nack", int'(a1), 0);
        chk("R5 bus unchanged", int'(reg_bus[31:0]), 32'h00C35AA0);

        // R10: block command with nonzero low bits refused.
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(8'h05, a1);
        bus_stop();
        chk("R10 bad block cmd nack", int'(a1), 0);

        // R7: block write count 3 fills registers 0..2 in order.
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(8'h00, a1);
        send_byte(8'h03, a2);
        send_byte(8'h31, a0);
        send_byte(8'h32, a1);
        send_byte(8'h33, a2);
        bus_stop();
        chk("R7 block acks", int'({a0, a1, a2}), 7);
        chk("R7 reg1", regv(1), 8'h32);
        chk("R7 reg2", regv(2), 8'h33);
        chk("R7 reg3 untouched", regv(3), 8'h00);

        // R7: stop after two of five bytes leaves the rest unchanged.
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(8'h00, a0);
        send_byte(8'h05, a0);
        send_byte(8'h41, a0);
        send_byte(8'h42, a0);
        bus_stop();
        chk("R7 early stop reg1", regv(1), 8'h42);
        chk("R7 early stop reg2", regv(2), 8'h33);

        // R8: byte beyond the count refused and not stored.
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(8'h00, a0);
        send_byte(8'h02, a0);
        send_byte(8'h51, a0);
        send_byte(8'h52, a1);
        send_byte(8'h53, a2);
        bus_stop();
        chk("R8 within count ack", int'(a1), 1);
        chk("R8 beyond count nack", int'(a2), 0);
        chk("R8 beyond count not stored", regv(2), 8'h33);

        // R8: count 8 then a ninth byte; last register boundary.
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(8'h00, a0);
        send_byte(8'h08, a0);
        for (int i = 0; i < 7; i++) send_byte(8'h60 + 8'(i), a0);
        send_byte(8'h67, a1);
        send_byte(8'h68, a2);
        bus_stop();
        chk("R8 eighth byte ack", int'(a1), 1);
        chk("R8 ninth byte nack", int'(a2), 0);
        chk("R6 reg7 read-only in block", regv(7), 8'hA7);

        // R9: block read returns count then registers ascending.
        exp_bank = '{8'hA0, 8'h61, 8'h62, 8'h63, 8'h64, 8'h65, 8'h66, 8'hA7};
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(8'h00, a1);
        bus_start();
        send_byte(8'hD3, a2);
        chk("R9 read address ack", int'({a0, a1, a2}), 7);
        recv_byte(1'b1, d);
        chk("R9 byte count", int'(d), 8);
        for (int i = 0; i < 8; i++) begin
            recv_byte(i != 7, d);
            chk("R9 block data", int'(d), int'(exp_bank[i]));
        end
        bus_stop();
        chk("R9 line released after nack", int'(sda_oe), 0);

        // R12: stop right after the command aborts without a write.
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(8'h83, a1);
        bus_stop();
        chk("R12 abort no write", regv(3), 8'h63);
        byte_read(8'h03, d);
        chk("R12 next transaction decodes", int'(d), 8'h63);

        // R11: no enable change while the clock line was high.
        chk("R11 sda changes with scl high", oe_viol, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule